// File: doc/BRIEF.md
# Daisy-chainable SPI frame interface

This block is an SPI slave front end for an eight-channel output driver. It runs entirely in the system clock domain: chip select, serial clock and serial input are first brought in through two-flop synchronizers, and their edges are then detected against one more registered copy. Each transaction trades a 16-bit control word from the host for a 16-bit diagnosis word. The diagnosis word is built from the per-channel open-load and fault flags, and it is captured at the moment chip select goes low.

The block counts the serial clocks in each chip-select window. When chip select is released, the frame is judged on that count. An accepted frame issues a one-cycle write strobe that carries the last 16 bits received. A rejected frame, a reset or limp-home operation sets a sticky error flag instead. Before the first serial clock, the serial output shows that flag ORed with the serial input, so a fault anywhere along a daisy chain appears at the host. Because the shift path is 16 bits long, a device in a chain with 8-bit or 16-bit neighbours passes the earlier bits of a longer frame on to the next device.

Top module: `spi_frame_if`

## Requirements
- R1: `so_oe_o` is 1 only while the synchronized chip select is low. While chip select is high, toggling `sclk_i` and `si_i` produces no write strobe.
- R2: On the chip-select falling edge the diagnosis word is captured. Bit 2k+1 of that word is `ol_flags_i[k]` and bit 2k is `fault_flags_i[k]`. The word is shifted out MSB first, with `so_o` changing on each serial-clock rising edge.
- R3: `si_i` is sampled on serial-clock falling edges, MSB first. On an accepted frame, `wr_data_o` takes the last 16 bits received, with the last bit received at bit 0, and holds that value until the next accepted frame.
- R4: From chip-select low until the first serial-clock rising edge, `so_o` equals the error flag ORed with the level of `si_i`.
- R5: A frame is accepted only if its serial-clock count is a multiple of 8 and at least 16. Zero clocks is rejected. An accepted frame raises `wr_o` for exactly one system clock cycle.
- R6: The error flag is set by reset and by a rejected frame, and cleared by an accepted frame. After reset, `wr_o` = 0, `wr_data_o` = 0 and `so_oe_o` = 0.
- R7: In a frame longer than 16 clocks, serial output bit i (i ≥ 16, counted from 0) equals serial input bit i−16.
- R8: While `limp_i` is 1, no write strobe is issued and the error flag is set.
- R9: The clock counter saturates without losing its value modulo 8. With the default counter width, a 64-clock frame is accepted and a 65-clock frame is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | SPI chip select, active low |
| sclk_i | input | 1 | SPI serial clock |
| si_i | input | 1 | SPI serial data in |
| ol_flags_i | input | NCH | Open-load flag per channel |
| fault_flags_i | input | NCH | Overload/overtemperature flag per channel |
| limp_i | input | 1 | Limp-home active |
| so_o | output | 1 | SPI serial data out |
| so_oe_o | output | 1 | Output enable for `so_o` (0 = high impedance) |
| wr_o | output | 1 | Control-register write strobe |
| wr_data_o | output | 2*NCH | Control word of the last accepted frame |

## Verification
The assertions assume that chip select never changes within a few system clocks of a serial-clock edge. They also assume that the serial input is stable around each serial-clock falling edge, so the synchronized copies keep their order. The stimulus holds each serial-clock phase for eight system clocks, sets the serial input together with the rising edge, and waits several cycles around every chip-select change. The flag inputs and the limp-home input are changed only while chip select is high.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned BYTE_LOG2   = 3;
endpackage

// File: rtl/spi_sync.sv
module spi_sync
  import spi_frame_pkg::*;
#(
  parameter int unsigned     WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [SYNC_STAGES-1:0] st;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st <= {SYNC_STAGES{RST_VAL[g]}};
      else         st <= {st[SYNC_STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = st[SYNC_STAGES-1];
  end
endmodule

// File: rtl/spi_bit_cnt.sv
module spi_bit_cnt
  import spi_frame_pkg::*;
#(
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned MIN_BYTES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic accept_o
);
  localparam int unsigned HI_W = CNT_W - BYTE_LOG2;
  localparam logic [HI_W-1:0] HI_MAX = '1;
  localparam logic [HI_W-1:0] HI_MIN = HI_W'(MIN_BYTES);

  logic [BYTE_LOG2-1:0] lo_q;
  logic [HI_W-1:0]      hi_q;

  // low bits always wrap, byte count saturates: modulo-8 stays exact
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (clr_i) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (inc_i) begin
      lo_q <= lo_q + 1'b1;
      if (&lo_q && hi_q != HI_MAX) hi_q <= hi_q + 1'b1;
    end
  end

  assign accept_o = (lo_q == '0) && (hi_q >= HI_MIN);

  AST_HI_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && hi_q == HI_MAX) |=> hi_q == HI_MAX); // R9
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  input  logic         bit_i,
  input  logic         out_i,
  output logic         so_q_o,
  output logic [W-1:0] data_o
);
  logic [W-1:0] sh_q;
  logic         so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      so_q <= 1'b0;
    end else begin
      if (load_i)       sh_q <= word_i;
      else if (shift_i) sh_q <= {sh_q[W-2:0], bit_i};
      if (out_i)        so_q <= sh_q[W-1];
    end
  end

  assign so_q_o = so_q;
  assign data_o = sh_q;
endmodule

// File: rtl/spi_frame_if.sv
module spi_frame_if
  import spi_frame_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned CNT_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 sclk_i,
  input  logic                 si_i,
  input  logic [NCH-1:0]       ol_flags_i,
  input  logic [NCH-1:0]       fault_flags_i,
  input  logic                 limp_i,
  output logic                 so_o,
  output logic                 so_oe_o,
  output logic                 wr_o,
  output logic [2*NCH-1:0]     wr_data_o
);
  localparam int unsigned W         = 2 * NCH;
  localparam int unsigned MIN_BYTES = W / 8;

  logic [2:0] sync_q;
  logic cs_s, sclk_s, si_s;
  logic cs_d, sclk_d;

  spi_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, si_i}),
    .q_o   (sync_q)
  );
  assign {cs_s, sclk_s, si_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  logic cs_fall, cs_rise, sck_rise, sck_fall;
  assign cs_fall  = cs_d & ~cs_s;
  assign cs_rise  = ~cs_d & cs_s;
  assign sck_rise = ~cs_s & sclk_s & ~sclk_d;
  assign sck_fall = ~cs_s & ~sclk_s & sclk_d;

  logic [W-1:0] diag_w;
  for (genvar k = 0; k < NCH; k++) begin : g_diag
    assign diag_w[2*k+1] = ol_flags_i[k];
    assign diag_w[2*k]   = fault_flags_i[k];
  end

  logic         accept;
  logic         so_q;
  logic [W-1:0] sh_data;

  spi_bit_cnt #(.CNT_W(CNT_W), .MIN_BYTES(MIN_BYTES)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cs_fall),
    .inc_i   (sck_fall),
    .accept_o(accept)
  );

  spi_shifter #(.W(W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cs_fall),
    .word_i (diag_w),
    .shift_i(sck_fall),
    .bit_i  (si_s),
    .out_i  (sck_rise),
    .so_q_o (so_q),
    .data_o (sh_data)
  );

  logic         err_q, wr_q, seen_q;
  logic [W-1:0] wr_data_q;
  logic         commit;
  assign commit = cs_rise & accept & ~limp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q     <= 1'b1;
      wr_q      <= 1'b0;
      wr_data_q <= '0;
      seen_q    <= 1'b0;
    end else begin
      if (limp_i)       err_q <= 1'b1;
      else if (cs_rise) err_q <= ~accept;
      wr_q <= commit;
      if (commit) wr_data_q <= sh_data;
      if (cs_s)          seen_q <= 1'b0;
      else if (sck_rise) seen_q <= 1'b1;
    end
  end

  assign so_o      = seen_q ? so_q : (err_q | si_s);
  assign so_oe_o   = ~cs_s;
  assign wr_o      = wr_q;
  assign wr_data_o = wr_data_q;

  AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o); // R5
  AST_NO_WR_LIMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> !$past(limp_i)); // R8
  AST_WR_CLEARS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> !err_q); // R6
  AST_REJECT_SETS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && !accept) |=> err_q); // R6
  AST_OE_OFF_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |-> !so_oe_o); // R1
endmodule

// File: tb/tb_spi_frame_if.sv
module tb_spi_frame_if;
  localparam int CLK_P = 10;
  localparam int HP    = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk = 1'b0, si = 1'b0, limp = 1'b0;
  logic [7:0] ol = '0, flt = '0;
  logic so, so_oe, wr;
  logic [15:0] wr_data;

  spi_frame_if dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk), .si_i(si),
    .ol_flags_i(ol), .fault_flags_i(flt), .limp_i(limp),
    .so_o(so), .so_oe_o(so_oe), .wr_o(wr), .wr_data_o(wr_data)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, wr_cnt = 0, oe_seen = 0;
  logic [15:0] wr_last;
  bit done = 0;

  always @(negedge clk) begin
    if (wr) begin wr_cnt++; wr_last = wr_data; end
    if (so_oe) oe_seen++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL R5 watchdog actual=%0d expected<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic [6:0]  nbits;
    logic [63:0] data;
    logic [7:0]  ol;
    logic [7:0]  flt;
    logic        exp_wr;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{7'd16, 64'hA5C3,             8'h81, 8'h42, 1'b1},
    '{7'd8,  64'h5A,               8'h0F, 8'hF0, 1'b0},
    '{7'd24, 64'h123456,           8'hFF, 8'h00, 1'b1},
    '{7'd17, 64'h1BEEF,            8'h00, 8'hFF, 1'b0},
    '{7'd32, 64'hDEADBEEF,         8'h3C, 8'hC3, 1'b1},
    '{7'd64, 64'h0123456789ABCDEF, 8'h55, 8'hAA, 1'b1},
    '{7'd65, 64'h7E81,             8'h00, 8'h00, 1'b0},
    '{7'd40, 64'hFFFFFF1234,       8'h18, 8'h24, 1'b1}
  };

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] diag_word(logic [7:0] o, logic [7:0] f);
    logic [15:0] w;
    for (int k = 0; k < 8; k++) begin
      w[2*k+1] = o[k];
      w[2*k]   = f[k];
    end
    return w;
  endfunction

  function automatic logic sent_bit(int nb, logic [63:0] d, int i);
    int p = nb - 1 - i;
    return (p < 64) ? d[p] : 1'b0;
  endfunction

  task automatic run_frame(int nb, logic [63:0] d, logic pre_si,
                           output logic pre_so, output logic [127:0] sob);
    sob = '0;
    wr_cnt = 0;
    si = pre_si;
    cs_ni = 1'b0;
    wait_clk(HP);
    pre_so = so;
    for (int i = 0; i < nb; i++) begin
      si = sent_bit(nb, d, i);
      sclk = 1'b1;
      wait_clk(HP);
      sob[i] = so;
      sclk = 1'b0;
      wait_clk(HP);
    end
    si = 1'b0;
    wait_clk(4);
    cs_ni = 1'b1;
    wait_clk(12);
  endtask

  initial begin
    logic pre;
    logic [127:0] sob, exp_so;
    logic err_exp;
    logic [15:0] dw;

    wait_clk(3);
    chk("R6", "reset wr", {127'b0, wr}, 128'd0);
    chk("R6", "reset wr_data", {112'b0, wr_data}, 128'd0);
    chk("R1", "reset so_oe", {127'b0, so_oe}, 128'd0);
    rst_ni = 1'b1;
    wait_clk(4);

    // R1: chip select high, clock and data toggled
    wr_cnt = 0; oe_seen = 0;
    for (int i = 0; i < 24; i++) begin
      si = i[1]; sclk = 1'b1; wait_clk(HP); sclk = 1'b0; wait_clk(HP);
    end
    wait_clk(12);
    chk("R1", "writes while cs high", 128'(wr_cnt), 128'd0);
    chk("R1", "so_oe while cs high", 128'(oe_seen), 128'd0);

    err_exp = 1'b1;
    for (int r = 0; r < 8; r++) begin
      ol = VECS[r].ol; flt = VECS[r].flt;
      dw = diag_word(VECS[r].ol, VECS[r].flt);
      run_frame(int'(VECS[r].nbits), VECS[r].data, 1'b0, pre, sob);
      chk("R4", $sformatf("row %0d pre-clock so (R6 flag)", r), {127'b0, pre}, {127'b0, err_exp});
      exp_so = '0;
      for (int i = 0; i < int'(VECS[r].nbits); i++)
        exp_so[i] = (i < 16) ? dw[15-i] : sent_bit(int'(VECS[r].nbits), VECS[r].data, i-16);
      chk("R2", $sformatf("row %0d so stream (R7)", r), sob, exp_so);
      chk("R5", $sformatf("row %0d write count (R9)", r), 128'(wr_cnt), 128'(VECS[r].exp_wr));
      if (VECS[r].exp_wr)
        chk("R3", $sformatf("row %0d write data", r), {112'b0, wr_last}, {112'b0, VECS[r].data[15:0]});
      chk("R3", $sformatf("row %0d held data", r), {112'b0, wr_data}, {112'b0, wr_last});
      err_exp = ~VECS[r].exp_wr;
    end

    // R5: zero-clock frame rejected, flag visible next frame
    run_frame(0, 64'h0, 1'b0, pre, sob);
    chk("R5", "zero-clock writes", 128'(wr_cnt), 128'd0);
    run_frame(16, 64'hC001, 1'b0, pre, sob);
    chk("R6", "flag after zero-clock frame", {127'b0, pre}, 128'd1);
    chk("R5", "recovery write", {112'b0, wr_last}, 128'hC001);

    // R4: flag clear, SI high shows through
    run_frame(16, 64'h0BAD, 1'b1, pre, sob);
    chk("R4", "so = si when flag clear", {127'b0, pre}, 128'd1);
    run_frame(16, 64'h1111, 1'b0, pre, sob);
    chk("R4", "so = 0 when flag clear and si low", {127'b0, pre}, 128'd0);

    // R8: limp-home
    limp = 1'b1;
    wait_clk(4);
    run_frame(16, 64'h7777, 1'b0, pre, sob);
    chk("R8", "writes in limp", 128'(wr_cnt), 128'd0);
    chk("R8", "data kept in limp", {112'b0, wr_data}, 128'h1111);
    limp = 1'b0;
    wait_clk(4);
    run_frame(16, 64'h2222, 1'b0, pre, sob);
    chk("R8", "flag after limp", {127'b0, pre}, 128'd1);

    // R6: reset mid-run sets flag
    rst_ni = 1'b0; wait_clk(3); rst_ni = 1'b1; wait_clk(4);
    chk("R6", "wr_data after reset", {112'b0, wr_data}, 128'd0);
    run_frame(16, 64'h3333, 1'b0, pre, sob);
    chk("R6", "flag after reset", {127'b0, pre}, 128'd1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule